// File: doc/BRIEF.md
# Endian-Selectable Word-to-Byte Downsizer

This block takes requests from a 64-bit upstream port and carries them out as single-byte transfers on an 8-bit downstream port. A request gives a command (read or write), a start byte address, a length in bytes and, optionally, a short byte-enable pattern. Write data comes in as whole words. Read data is collected byte by byte and goes back upstream as whole words. A parameter sets the serialization order. In big-endian mode each word leaves most significant byte first, so the most significant byte lands at the lowest address. In little-endian mode the bytes go out in their natural order.

The shape of each request is checked before any data moves. A length that is not a whole number of words is refused, and so is an enable pattern whose length does not divide the word width. Both cases finish at once with their own status codes. An enable pattern shorter than a word repeats across the burst, and each enable stays with its own data byte whatever the byte order. Only one request is in flight at a time. Every port uses a valid/ready handshake.

Top module: `dsz_downsizer`

## Requirements
- R1: `req_ready` is high only while the block is idle. While a request is being carried out, no new request is accepted and `req_ready` stays low until the response has been taken.
- R2: A request with `req_len` not a multiple of 8 gets `rsp_valid` with `rsp_status`=1 in the cycle after acceptance, with no downstream transfer. This check comes before the enable check.
- R3: A request with `req_be_on`=1 whose `req_be_len` (4-bit count, 0..15) is not 1, 2, 4 or 8 gets `rsp_status`=2 in the cycle after acceptance, with no downstream transfer. When `req_be_on`=0, `req_be_len` is ignored.
- R4: Upstream byte i of a word is `data[8i+7:8i]`. With `BIG_ENDIAN`=1 the k-th downstream byte of each word is upstream byte 7-k. With `BIG_ENDIAN`=0 it is upstream byte k.
- R5: Downstream addresses start at `req_addr` and rise by one for each byte position, including positions whose enable is clear.
- R6: When enables are on, upstream byte i of word w carries enable `req_be_pat[(8w+i) mod req_be_len]`, and that enable is presented on `dn_strb` together with that byte. A cleared enable still produces a transfer, with `dn_strb`=0. When enables are off, `dn_strb`=1.
- R7: A burst of N words takes N words on the write-data port, in order, and reorders each word on its own.
- R8: On reads, `dn_strb` is 1. Each returned byte is placed in the same word lane that a write would have taken it from. A word is offered on `rdat_*` after its 8th byte, with `rdat_last` high on the final word.
- R9: A legal request ends with `rsp_status`=0, raised only after the last downstream byte has completed (and, for reads, after the last word has been taken). `rsp_valid` and `rsp_status` hold until `rsp_ready`.
- R10: A legal request with `req_len`=0 gets `rsp_status`=0 in the cycle after acceptance, with no downstream transfer.
- R11: While `dn_valid` is high and `dn_ready` is low, the downstream command, address, data and strobe hold steady. While `rdat_valid` is high and `rdat_ready` is low, the read word holds steady.
- R12: After reset, `req_ready`=1 and `dn_valid`, `rdat_valid`, `rsp_valid`, `wdat_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| req_be_on | input | 1 | Enable pattern present |
| req_be_len | input | clog2(WORD_BYTES)+1 | Enable pattern length |
| req_be_pat | input | WORD_BYTES | Enable pattern, bit i = element i |
| wdat_valid | input | 1 | Write word offered |
| wdat_ready | output | 1 | Write word taken |
| wdat_data | input | 8*WORD_BYTES | Write word |
| rdat_valid | output | 1 | Read word offered |
| rdat_ready | input | 1 | Read word taken |
| rdat_data | output | 8*WORD_BYTES | Read word |
| rdat_last | output | 1 | Final read word of the burst |
| rsp_valid | output | 1 | Completion offered |
| rsp_ready | input | 1 | Completion taken |
| rsp_status | output | 2 | 0 ok, 1 length error, 2 enable error |
| dn_valid | output | 1 | Downstream byte transfer offered |
| dn_ready | input | 1 | Downstream transfer taken |
| dn_write | output | 1 | Downstream command |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_wdata | output | 8 | Downstream write byte |
| dn_strb | output | 1 | Byte enable for this transfer |
| dn_rvalid | input | 1 | Read byte returned |
| dn_rdata | input | 8 | Returned read byte |

## Verification
The hardest case to reach from the ports is a masked byte inside a multi-word, unaligned burst while downstream `dn_ready` stalls. Only there do the enable repetition, the byte reversal and the address counting all act on the same transfer. To get there, the stimulus sweeps every legal pattern length against bursts of one to three words at shifting start addresses. It runs a big-endian and a little-endian instance side by side on one pseudo-random ready pattern, and compares each one's memory model with shadow memory worked out from the formula for that byte order.

// File: rtl/dsz_pkg.sv
package dsz_pkg;
  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_BURST_ERR = 2'd1,
    ST_BE_ERR    = 2'd2
  } dsz_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WFETCH,
    S_WSEND,
    S_RSEND,
    S_RWAIT,
    S_RWORD,
    S_RESP
  } dsz_state_e;
endpackage

// File: rtl/dsz_shape_check.sv
module dsz_shape_check #(
  parameter int WORD_BYTES = 8,
  parameter int LEN_W      = 12,
  parameter int PAT_LEN_W  = 4
) (
  input  logic [LEN_W-1:0]     len,
  input  logic                 be_on,
  input  logic [PAT_LEN_W-1:0] be_len,
  output logic                 burst_err,
  output logic                 be_err
);
  localparam logic [LEN_W-1:0]     LEN_MASK = LEN_W'(WORD_BYTES - 1);
  localparam logic [PAT_LEN_W-1:0] PAT_MAX  = PAT_LEN_W'(WORD_BYTES);

  logic [PAT_LEN_W-1:0] be_len_m1;
  logic                 pow2;

  always_comb begin
    be_len_m1 = be_len - 1'b1;
    pow2      = (be_len != '0) && ((be_len & be_len_m1) == '0);
    burst_err = (len & LEN_MASK) != '0;
    be_err    = be_on && !(pow2 && (be_len <= PAT_MAX));
  end
endmodule

// File: rtl/dsz_lane_sel.sv
module dsz_lane_sel #(
  parameter int WORD_BYTES = 8,
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int LANE_W     = 3
) (
  input  logic [8*WORD_BYTES-1:0] word,
  input  logic [LANE_W-1:0]       pos,
  input  logic [WORD_BYTES-1:0]   pat,
  input  logic [LANE_W-1:0]       pat_mask,
  input  logic                    be_on,
  output logic [LANE_W-1:0]       lane,
  output logic [7:0]              byte_o,
  output logic                    en_o
);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(WORD_BYTES - 1);

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = TOP_LANE - pos;
    end else begin : g_little
      assign lane = pos;
    end
  endgenerate

  logic [LANE_W-1:0] pat_idx;

  always_comb begin
    pat_idx = lane & pat_mask;
    byte_o  = word[8*lane +: 8];
    en_o    = be_on ? pat[pat_idx] : 1'b1;
  end
endmodule

// File: rtl/dsz_rd_gather.sv
module dsz_rd_gather #(
  parameter int WORD_BYTES = 8,
  parameter int LANE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [LANE_W-1:0]       lane,
  input  logic [7:0]              din,
  output logic [8*WORD_BYTES-1:0] word
);
  genvar gi;
  generate
    for (gi = 0; gi < WORD_BYTES; gi++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          word[8*gi +: 8] <= '0;
        end else if (wr_en && (lane == LANE_W'(gi))) begin
          word[8*gi +: 8] <= din;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dsz_downsizer.sv
module dsz_downsizer
  import dsz_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  input  logic                          req_be_on,
  input  logic [$clog2(WORD_BYTES):0]   req_be_len,
  input  logic [WORD_BYTES-1:0]         req_be_pat,
  input  logic                          wdat_valid,
  output logic                          wdat_ready,
  input  logic [8*WORD_BYTES-1:0]       wdat_data,
  output logic                          rdat_valid,
  input  logic                          rdat_ready,
  output logic [8*WORD_BYTES-1:0]       rdat_data,
  output logic                          rdat_last,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [1:0]                    rsp_status,
  output logic                          dn_valid,
  input  logic                          dn_ready,
  output logic                          dn_write,
  output logic [ADDR_W-1:0]             dn_addr,
  output logic [7:0]                    dn_wdata,
  output logic                          dn_strb,
  input  logic                          dn_rvalid,
  input  logic [7:0]                    dn_rdata
);
  localparam int LANE_W    = $clog2(WORD_BYTES);
  localparam int PAT_LEN_W = LANE_W + 1;
  localparam int WORD_W    = 8 * WORD_BYTES;
  localparam int WCNT_W    = LEN_W - LANE_W;
  localparam logic [LANE_W-1:0] LAST_POS = LANE_W'(WORD_BYTES - 1);
  localparam logic [WCNT_W-1:0] ONE_WORD = WCNT_W'(1);

  dsz_state_e          state;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANE_W-1:0]   pos_q;
  logic [WCNT_W-1:0]   wleft_q;
  logic [WORD_W-1:0]   wbuf_q;
  logic                is_wr_q;
  logic                be_on_q;
  logic [WORD_BYTES-1:0] pat_q;
  logic [LANE_W-1:0]   mask_q;
  dsz_status_e         status_q;

  logic                burst_err;
  logic                be_err;
  logic [PAT_LEN_W-1:0] mask_d;
  logic [LANE_W-1:0]   cur_lane;
  logic [7:0]          cur_byte;
  logic                cur_en;
  logic                gather_en;

  dsz_shape_check #(
    .WORD_BYTES (WORD_BYTES),
    .LEN_W      (LEN_W),
    .PAT_LEN_W  (PAT_LEN_W)
  ) u_check (
    .len       (req_len),
    .be_on     (req_be_on),
    .be_len    (req_be_len),
    .burst_err (burst_err),
    .be_err    (be_err)
  );

  dsz_lane_sel #(
    .WORD_BYTES (WORD_BYTES),
    .BIG_ENDIAN (BIG_ENDIAN),
    .LANE_W     (LANE_W)
  ) u_lane (
    .word     (wbuf_q),
    .pos      (pos_q),
    .pat      (pat_q),
    .pat_mask (mask_q),
    .be_on    (be_on_q),
    .lane     (cur_lane),
    .byte_o   (cur_byte),
    .en_o     (cur_en)
  );

  assign gather_en = (state == S_RWAIT) && dn_rvalid;

  dsz_rd_gather #(
    .WORD_BYTES (WORD_BYTES),
    .LANE_W     (LANE_W)
  ) u_gather (
    .clk   (clk),
    .rst   (rst),
    .wr_en (gather_en),
    .lane  (cur_lane),
    .din   (dn_rdata),
    .word  (rdat_data)
  );

  assign mask_d = req_be_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      pos_q    <= '0;
      wleft_q  <= '0;
      wbuf_q   <= '0;
      is_wr_q  <= 1'b0;
      be_on_q  <= 1'b0;
      pat_q    <= '0;
      mask_q   <= '0;
      status_q <= ST_OK;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            pos_q   <= '0;
            wleft_q <= req_len[LEN_W-1:LANE_W];
            is_wr_q <= req_write;
            be_on_q <= req_be_on;
            pat_q   <= req_be_pat;
            mask_q  <= mask_d[LANE_W-1:0];
            if (burst_err) begin
              status_q <= ST_BURST_ERR;
              state    <= S_RESP;
            end else if (be_err) begin
              status_q <= ST_BE_ERR;
              state    <= S_RESP;
            end else begin
              status_q <= ST_OK;
              if (req_len == '0)  state <= S_RESP;
              else if (req_write) state <= S_WFETCH;
              else                state <= S_RSEND;
            end
          end
        end
        S_WFETCH: begin
          if (wdat_valid) begin
            wbuf_q <= wdat_data;
            pos_q  <= '0;
            state  <= S_WSEND;
          end
        end
        S_WSEND: begin
          if (dn_ready) begin
            addr_q <= addr_q + 1'b1;
            pos_q  <= pos_q + 1'b1;
            if (pos_q == LAST_POS) begin
              wleft_q <= wleft_q - 1'b1;
              state   <= (wleft_q == ONE_WORD) ? S_RESP : S_WFETCH;
            end
          end
        end
        S_RSEND: begin
          if (dn_ready) state <= S_RWAIT;
        end
        S_RWAIT: begin
          if (dn_rvalid) begin
            addr_q <= addr_q + 1'b1;
            pos_q  <= pos_q + 1'b1;
            state  <= (pos_q == LAST_POS) ? S_RWORD : S_RSEND;
          end
        end
        S_RWORD: begin
          if (rdat_ready) begin
            wleft_q <= wleft_q - 1'b1;
            state   <= (wleft_q == ONE_WORD) ? S_RESP : S_RSEND;
          end
        end
        S_RESP: begin
          if (rsp_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign wdat_ready = (state == S_WFETCH);
  assign dn_valid   = (state == S_WSEND) || (state == S_RSEND);
  assign dn_write   = is_wr_q;
  assign dn_addr    = addr_q;
  assign dn_wdata   = is_wr_q ? cur_byte : 8'h00;
  assign dn_strb    = is_wr_q ? cur_en : 1'b1;
  assign rdat_valid = (state == S_RWORD);
  assign rdat_last  = (wleft_q == ONE_WORD);
  assign rsp_valid  = (state == S_RESP);
  assign rsp_status = status_q;
endmodule

// File: rtl/dsz_downsizer_chk.sv
module dsz_downsizer_chk #(
  parameter int WORD_BYTES = 8,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [LEN_W-1:0]            req_len,
  input logic                        req_be_on,
  input logic [$clog2(WORD_BYTES):0] req_be_len,
  input logic                        wdat_ready,
  input logic                        rdat_valid,
  input logic                        rdat_ready,
  input logic [8*WORD_BYTES-1:0]     rdat_data,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic [1:0]                  rsp_status,
  input logic                        dn_valid,
  input logic                        dn_ready,
  input logic                        dn_write,
  input logic [ADDR_W-1:0]           dn_addr,
  input logic [7:0]                  dn_wdata,
  input logic                        dn_strb
);
  logic take, misaligned, pat_legal;
  assign take       = req_valid && req_ready;
  assign misaligned = (req_len % WORD_BYTES) != 0;
  assign pat_legal  = ($countones(req_be_len) == 1) && (req_be_len <= WORD_BYTES);

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !dn_valid && !rdat_valid && !rsp_valid); // R1
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_ready, wdat_ready, dn_valid, rdat_valid, rsp_valid})); // R1
  AST_BURST_ERR: assert property (@(posedge clk) disable iff (rst)
    take && misaligned |=> rsp_valid && rsp_status == 2'd1); // R2
  AST_BE_ERR: assert property (@(posedge clk) disable iff (rst)
    take && !misaligned && req_be_on && !pat_legal |=> rsp_valid && rsp_status == 2'd2); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_ready && dn_write |=> dn_addr == ADDR_W'($past(dn_addr) + 1'b1)); // R5
  AST_RD_STRB: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_write |-> dn_strb); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status)); // R9
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata)
      && $stable(dn_strb) && $stable(dn_write)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rdat_valid && !rdat_ready |=> rdat_valid && $stable(rdat_data)); // R11
endmodule

bind dsz_downsizer dsz_downsizer_chk #(
  .WORD_BYTES (WORD_BYTES),
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_len    (req_len),
  .req_be_on  (req_be_on),
  .req_be_len (req_be_len),
  .wdat_ready (wdat_ready),
  .rdat_valid (rdat_valid),
  .rdat_ready (rdat_ready),
  .rdat_data  (rdat_data),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .dn_valid   (dn_valid),
  .dn_ready   (dn_ready),
  .dn_write   (dn_write),
  .dn_addr    (dn_addr),
  .dn_wdata   (dn_wdata),
  .dn_strb    (dn_strb)
);

// File: tb/dsz_downsizer_tb.sv
module dsz_downsizer_tb;
  localparam int AW = 16;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic          req_valid = 0, req_write = 0, req_be_on = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [3:0]    req_be_len = '0;
  logic [7:0]    req_be_pat = '0;
  logic          wdat_valid = 0, rdat_ready = 0, rsp_ready = 0, dn_ready = 0;
  logic [63:0]   wdat_data = '0;

  logic req_ready, wdat_ready, rdat_valid, rdat_last, rsp_valid;
  logic [63:0] rdat_b, rdat_l;
  logic [1:0]  rsp_status;
  logic        dv_b, dw_b, ds_b, dv_l, dw_l, ds_l;
  logic [AW-1:0] da_b, da_l;
  logic [7:0]  dd_b, dd_l;
  logic        rv_b = 0, rv_l = 0;
  logic [7:0]  rd_b = 0, rd_l = 0;
  logic        u_rr, u_wr, u_rv, u_rl, u_sv;
  logic [1:0]  u_st;

  dsz_downsizer #(.ADDR_W(AW), .LEN_W(LW), .BIG_ENDIAN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_be_on(req_be_on), .req_be_len(req_be_len), .req_be_pat(req_be_pat),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_data(rdat_b),
    .rdat_last(rdat_last), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .dn_valid(dv_b), .dn_ready(dn_ready),
    .dn_write(dw_b), .dn_addr(da_b), .dn_wdata(dd_b), .dn_strb(ds_b),
    .dn_rvalid(rv_b), .dn_rdata(rd_b));

  dsz_downsizer #(.ADDR_W(AW), .LEN_W(LW), .BIG_ENDIAN(1'b0)) u_dut_le (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(u_rr),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_be_on(req_be_on), .req_be_len(req_be_len), .req_be_pat(req_be_pat),
    .wdat_valid(wdat_valid), .wdat_ready(u_wr), .wdat_data(wdat_data),
    .rdat_valid(u_rv), .rdat_ready(rdat_ready), .rdat_data(rdat_l),
    .rdat_last(u_rl), .rsp_valid(u_sv), .rsp_ready(rsp_ready),
    .rsp_status(u_st), .dn_valid(dv_l), .dn_ready(dn_ready),
    .dn_write(dw_l), .dn_addr(da_l), .dn_wdata(dd_l), .dn_strb(ds_l),
    .dn_rvalid(rv_l), .dn_rdata(rd_l));

  // byte memories and shadows
  logic [7:0] mem_b [256];
  logic [7:0] mem_l [256];
  logic [7:0] sh_b [256];
  logic [7:0] sh_l [256];
  int hs_cnt = 0;
  int hold_viol = 0;
  logic        pv; logic [AW-1:0] pa; logic [7:0] pd; logic ps, pw;

  always @(posedge clk) begin
    rv_b <= dv_b && dn_ready && !dw_b;
    rv_l <= dv_l && dn_ready && !dw_l;
    rd_b <= mem_b[da_b[7:0]];
    rd_l <= mem_l[da_l[7:0]];
    if (dv_b && dn_ready && dw_b && ds_b) mem_b[da_b[7:0]] <= dd_b;
    if (dv_l && dn_ready && dw_l && ds_l) mem_l[da_l[7:0]] <= dd_l;
    if (dv_b && dn_ready) hs_cnt <= hs_cnt + 1;
    if (!rst && pv && (!dv_b || da_b != pa || dd_b != pd || ds_b != ps || dw_b != pw))
      hold_viol <= hold_viol + 1;
    pv <= dv_b && !dn_ready; pa <= da_b; pd <= dd_b; ps <= ds_b; pw <= dw_b;
  end

  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dn_ready <= lfsr[0] | lfsr[3];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] wbuf [8];
  logic [63:0] rb_b [8];
  logic [63:0] rb_l [8];
  logic        rlast [8];
  int          nread, rsp_lat, rsp_hs, busy_ready;
  logic [1:0]  got_st, got_st_l;

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [LW-1:0] len,
                      input bit be, input logic [3:0] bl, input logic [7:0] pat, input int hold);
    int widx = 0; int cyc = 0; int seen = 0; bit done = 0;
    nread = 0; busy_ready = 0; rsp_lat = -1;
    @(negedge clk);
    hs_cnt = 0;
    req_write = wr; req_addr = a; req_len = len; req_be_on = be;
    req_be_len = bl; req_be_pat = pat; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && cyc < 2000) begin
      cyc++;
      wdat_valid = 1; wdat_data = wbuf[widx % 8];
      rdat_ready = cyc[0] | cyc[1];
      rsp_ready  = (seen >= hold);
      if (req_ready && !rsp_valid) busy_ready++;
      if (wdat_valid && wdat_ready) widx++;
      if (rdat_valid && rdat_ready) begin
        rb_b[nread % 8] = rdat_b; rb_l[nread % 8] = rdat_l;
        rlast[nread % 8] = rdat_last; nread++;
      end
      if (rsp_valid) begin
        if (seen == 0) begin rsp_lat = cyc; rsp_hs = hs_cnt; end
        seen++;
        got_st = rsp_status; got_st_l = u_st;
        if (rsp_ready) done = 1;
      end
      @(negedge clk);
    end
    wdat_valid = 0; rdat_ready = 0; rsp_ready = 0;
    if (!done) chk(0, "R9 timeout", 64'(cyc), 64'd0);
  endtask

  task automatic shadow_write(input logic [AW-1:0] a, input int len, input bit be,
                              input int bl, input logic [7:0] pat);
    for (int w = 0; w < len / 8; w++)
      for (int k = 0; k < 8; k++) begin
        int lb = 7 - k; int ll = k;
        if (!be || pat[lb % bl]) sh_b[8'(a + 16'(w*8 + k))] = wbuf[w][8*lb +: 8];
        if (!be || pat[ll % bl]) sh_l[8'(a + 16'(w*8 + k))] = wbuf[w][8*ll +: 8];
      end
  endtask

  task automatic cmp_mem(input string req);
    int bad_b = 0; int bad_l = 0; int ib = 0; int il = 0;
    for (int i = 0; i < 256; i++) begin
      if (mem_b[i] !== sh_b[i]) begin if (bad_b == 0) ib = i; bad_b++; end
      if (mem_l[i] !== sh_l[i]) begin if (bad_l == 0) il = i; bad_l++; end
    end
    chk(bad_b == 0, {req, " big-endian memory"}, 64'(mem_b[ib]), 64'(sh_b[ib]));
    chk(bad_l == 0, {req, " little-endian memory"}, 64'(mem_l[il]), 64'(sh_l[il]));
  endtask

  task automatic err_case(input bit wr, input int len, input bit be, input int bl,
                          input logic [1:0] exp_st, input string req);
    xfer(wr, 16'd40, LW'(len), be, 4'(bl), 8'hFF, 0);
    chk(got_st == exp_st && got_st_l == exp_st, req, 64'(got_st), 64'(exp_st));
    chk(rsp_lat == 1, {req, " latency"}, 64'(rsp_lat), 64'd1);
    chk(hs_cnt == 0, {req, " no transfer"}, 64'(hs_cnt), 64'd0);
  endtask

  initial begin
    logic [7:0] pats [6];
    int bls [6];
    bit bes [6];
    bes[0]=0; bls[0]=8; pats[0]=8'h00;
    bes[1]=1; bls[1]=1; pats[1]=8'h01;
    bes[2]=1; bls[2]=2; pats[2]=8'h01;
    bes[3]=1; bls[3]=4; pats[3]=8'h06;
    bes[4]=1; bls[4]=8; pats[4]=8'h3F;
    bes[5]=1; bls[5]=1; pats[5]=8'h00;
    for (int i = 0; i < 256; i++) begin
      mem_b[i] = 8'(i * 7 + 3); mem_l[i] = 8'(i * 7 + 3);
      sh_b[i]  = 8'(i * 7 + 3); sh_l[i]  = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(req_ready && !dv_b && !rdat_valid && !rsp_valid && !wdat_ready, "R12 reset outputs",
        {59'd0, req_ready, dv_b, rdat_valid, rsp_valid, wdat_ready}, 64'h10);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R12 idle after reset", 64'(req_ready), 64'd1);

    // sweep enable patterns x burst lengths, write then read back
    for (int c = 0; c < 6; c++)
      for (int nw = 1; nw <= 3; nw++) begin
        logic [AW-1:0] a = AW'(c*40 + nw*3);
        for (int w = 0; w < 8; w++)
          for (int j = 0; j < 8; j++) wbuf[w][8*j +: 8] = 8'(c*50 + w*16 + j + 1);
        xfer(1, a, LW'(nw*8), bes[c], 4'(bls[c]), pats[c], (c == 2) ? 3 : 0);
        shadow_write(a, nw*8, bes[c], bls[c], pats[c]);
        chk(got_st == 2'd0 && got_st_l == 2'd0, "R9 write status", 64'(got_st), 64'd0);
        chk(rsp_hs == nw*8, "R9 response after last byte", 64'(rsp_hs), 64'(nw*8));
        chk(hs_cnt == nw*8, "R5 R6 one transfer per byte", 64'(hs_cnt), 64'(nw*8));
        chk(busy_ready == 0, "R1 busy while writing", 64'(busy_ready), 64'd0);
        cmp_mem((c == 0) ? "R4 R7 byte order" : "R6 enable mapping");
        xfer(0, a, LW'(nw*8), bes[c], 4'(bls[c]), pats[c], 0);
        chk(nread == nw, "R8 read word count", 64'(nread), 64'(nw));
        chk(got_st == 2'd0, "R9 read status", 64'(got_st), 64'd0);
        chk(busy_ready == 0, "R1 busy while reading", 64'(busy_ready), 64'd0);
        for (int w = 0; w < nw; w++) begin
          logic [63:0] eb, el;
          for (int j = 0; j < 8; j++) begin
            eb[8*j +: 8] = sh_b[8'(a + 16'(w*8 + 7 - j))];
            el[8*j +: 8] = sh_l[8'(a + 16'(w*8 + j))];
          end
          chk(rb_b[w] == eb, "R8 big-endian read lanes", rb_b[w], eb);
          chk(rb_l[w] == el, "R8 little-endian read lanes", rb_l[w], el);
          chk(rlast[w] == (w == nw - 1), "R8 last flag", 64'(rlast[w]), 64'(w == nw - 1));
        end
      end

    // shape errors
    err_case(1, 5, 0, 1, 2'd1, "R2 short length");
    err_case(0, 9, 0, 1, 2'd1, "R2 read misaligned");
    err_case(1, 12, 1, 3, 2'd1, "R2 priority over enable error");
    err_case(1, 8, 1, 3, 2'd2, "R3 pattern length 3");
    err_case(0, 16, 1, 0, 2'd2, "R3 pattern length 0");
    err_case(1, 8, 1, 15, 2'd2, "R3 pattern length 15");
    err_case(1, 0, 0, 8, 2'd0, "R10 zero length");
    cmp_mem("R2 R3 R10 memory untouched");

    // enable length ignored when enables are off
    for (int j = 0; j < 8; j++) wbuf[0][8*j +: 8] = 8'(200 + j);
    xfer(1, 16'd100, LW'(8), 0, 4'd3, 8'h00, 0);
    shadow_write(16'd100, 8, 0, 8, 8'h00);
    chk(got_st == 2'd0, "R3 pattern length ignored", 64'(got_st), 64'd0);
    cmp_mem("R3 full write with enables off");

    chk(hold_viol == 0, "R11 downstream hold", 64'(hold_viol), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule